// File: doc/BRIEF.md
# Memory-Mapped IDE Register Bridge

This block lets a memory-mapped bus master reach the registers of an IDE/ATA drive. A 4 KB address window is split into 16-byte register slots. The slot number selects the drive register. The access width decides which path is taken:

- **Single-byte accesses** reach the seven task-file registers and the control/status register. The control/status register can be reached through two slot numbers.
- **Halfword and word accesses** reach only the data port.

Every other combination of width and slot is treated as unmapped. An unmapped read returns all-ones at the access width. An unmapped write is dropped, and the drive sees no strobe.

On the drive side the bridge presents a small strobe interface: a register select, a width, write data, and single-cycle read or write strobes. Read data comes back in the same cycle as the read strobe. A static configuration input chooses big-endian handling. In that mode, halfword and word data-port values are byte-reversed in both directions, so a big-endian host sees the drive's little-endian data stream in its natural order.

The bus handshake is a request that the master holds until it sees a one-cycle ready pulse. Read data is registered and is valid in that same ready cycle.

Top module: `mmio_ide_bridge`

## Requirements
- R1: The register slot is taken from address bits [11:4]. Every address bit above 11 and below 4 has no effect on routing or data.
- R2: A byte access (size 2'b00) to slot 1..7 reads or writes drive register 1..7 (dev_reg = slot). Write data is on dev_wdata[7:0] with the upper bits zero, and read data is dev_rdata[7:0] zero-extended.
- R3: A byte access to slot 8 or slot 22 targets dev_reg 8. A write there is a device-control write, and a read returns the alternate status value.
- R4: A byte access to any slot other than 1..7, 8 or 22 (slot 0 included) produces no strobe. On a read it returns 32'h000000FF.
- R5: A halfword (2'b01) or word (2'b10, and 2'b11 treated as word) access reaches the data port (dev_reg 0) only at slot 0. At any other slot it produces no strobe, and a read returns 32'h0000FFFF or 32'hFFFFFFFF respectively.
- R6: With big-endian mode active, halfword and word data-port values are byte-reversed on both write and read. Byte accesses are never reversed.
- R7: Big-endian mode is taken from cfg_big_endian on the first clock after reset release. Later changes of that input have no effect until the next reset.
- R8: bus_ready is a single-cycle pulse, two clocks after the edge that accepts the request. bus_rdata holds the read result in that cycle.
- R9: Each mapped access gives exactly one one-cycle strobe: dev_rd for a read, dev_wr for a write, and never both together. Unmapped accesses give none.
- R10: After reset, bus_ready, dev_rd and dev_wr are low and bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_endian | input | 1 | Big-endian data-port mode, taken after reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, right-aligned |
| dev_reg | output | 4 | 0 data port, 1..7 task file, 8 control/status |
| dev_size | output | 2 | Width of the drive access |
| dev_wdata | output | 32 | Data written to the drive |
| dev_rd | output | 1 | One-cycle read strobe |
| dev_wr | output | 1 | One-cycle write strobe |
| dev_rdata | input | 32 | Drive read data, valid with dev_rd |

## Verification
The hardest state to reach from the ports is a late change on cfg_big_endian. The mode is frozen right after reset, so a wrong design that follows the live pin agrees with a correct one for as long as the pin is left alone. The bench therefore resets a second time with the pin high, waits for the capture, and then drives it low. After that it repeats data-port writes and reads and expects them to stay byte-reversed.

Slot aliasing through the ignored address bits is covered by randomising those bits on every random access. Accesses to the second control/status slot and to the data slot with a byte width are forced by directed cases.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACCESS = 2'b01,
    ST_DONE   = 2'b10
  } bridge_state_e;

  localparam int unsigned DEV_REG_W = 4;
  localparam logic [DEV_REG_W-1:0] DREG_DATA = 4'd0;
  localparam logic [DEV_REG_W-1:0] DREG_CTRL = 4'd8;

  typedef struct packed {
    logic                 hit;
    logic [DEV_REG_W-1:0] sel;
  } route_t;

endpackage

// File: rtl/ide_reg_decode.sv
module ide_reg_decode
  import ide_bridge_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CTRL_A = 8,
  parameter int unsigned CTRL_B = 22
) (
  input  logic [IDX_W-1:0] idx,
  input  acc_size_e        size,
  output route_t           route
);

  localparam logic [IDX_W-1:0] CTRL_A_L = IDX_W'(CTRL_A);
  localparam logic [IDX_W-1:0] CTRL_B_L = IDX_W'(CTRL_B);

  always_comb begin
    route.hit = 1'b0;
    route.sel = DREG_DATA;
    if (size == SZ_BYTE) begin
      if (idx >= IDX_W'(1) && idx <= IDX_W'(7)) begin
        route.hit = 1'b1;
        route.sel = DEV_REG_W'(idx[2:0]);
      end else if (idx == CTRL_A_L || idx == CTRL_B_L) begin
        route.hit = 1'b1;
        route.sel = DREG_CTRL;
      end
    end else if (idx == '0) begin
      route.hit = 1'b1;
      route.sel = DREG_DATA;
    end
  end

  // a hit never selects a register beyond the control slot
  always_comb begin
    AST_SEL_RANGE: assert (!route.hit || route.sel <= DREG_CTRL); // R2
  end

endmodule

// File: rtl/ide_lane_swap.sv
module ide_lane_swap #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES*8-1:0] din,
  output logic [LANES*8-1:0] dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*8 +: 8] = din[(LANES-1-g)*8 +: 8];
  end

endmodule

// File: rtl/ide_data_fmt.sv
module ide_data_fmt
  import ide_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  acc_size_e         size,
  input  logic              big_endian,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned HALF_W = 16;

  logic [HALF_W-1:0] half_sw;
  logic [DATA_W-1:0] word_sw;

  ide_lane_swap #(.LANES(HALF_W/8)) i_swap_half (
    .din  (din[HALF_W-1:0]),
    .dout (half_sw)
  );

  ide_lane_swap #(.LANES(DATA_W/8)) i_swap_word (
    .din  (din),
    .dout (word_sw)
  );

  always_comb begin
    unique case (size)
      SZ_BYTE: dout = DATA_W'(din[7:0]);
      SZ_HALF: dout = DATA_W'(big_endian ? half_sw : din[HALF_W-1:0]);
      default: dout = big_endian ? word_sw : din;
    endcase
  end

endmodule

// File: rtl/mmio_ide_bridge.sv
module mmio_ide_bridge
  import ide_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SLOT_LSB  = 4,
  parameter int unsigned SLOT_W    = 8,
  parameter int unsigned CTRL_SLOT_A = 8,
  parameter int unsigned CTRL_SLOT_B = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_endian,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [3:0]        dev_reg,
  output logic [1:0]        dev_size,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dev_rd,
  output logic              dev_wr,
  input  logic [DATA_W-1:0] dev_rdata
);

  localparam int unsigned SLOT_HI = SLOT_LSB + SLOT_W - 1;

  // ---- reset: asserted asynchronously, released on the clock ----
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // ---- ignored offset bits ----
  logic unused_addr_bits;
  if (ADDR_W > SLOT_HI + 1) begin : g_hi_bits
    assign unused_addr_bits = ^{bus_addr[ADDR_W-1:SLOT_HI+1], bus_addr[SLOT_LSB-1:0]};
  end else begin : g_no_hi_bits
    assign unused_addr_bits = ^bus_addr[SLOT_LSB-1:0];
  end

  // ---- configuration capture ----
  logic be_q, be_d, cfg_seen_q, cfg_seen_d;

  always_comb begin
    be_d       = be_q;
    cfg_seen_d = cfg_seen_q;
    if (!cfg_seen_q) begin
      be_d       = cfg_big_endian;
      cfg_seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      be_q       <= 1'b0;
      cfg_seen_q <= 1'b0;
    end else begin
      be_q       <= be_d;
      cfg_seen_q <= cfg_seen_d;
    end
  end

  // ---- decode and data formatting ----
  acc_size_e         req_size;
  route_t            req_route;
  logic [DATA_W-1:0] wdata_fmt;
  logic [DATA_W-1:0] rd_src;
  logic [DATA_W-1:0] rdata_fmt;

  assign req_size = acc_size_e'(bus_size);

  ide_reg_decode #(
    .IDX_W  (SLOT_W),
    .CTRL_A (CTRL_SLOT_A),
    .CTRL_B (CTRL_SLOT_B)
  ) i_decode (
    .idx   (bus_addr[SLOT_HI:SLOT_LSB]),
    .size  (req_size),
    .route (req_route)
  );

  ide_data_fmt #(.DATA_W(DATA_W)) i_wr_fmt (
    .size       (req_size),
    .big_endian (be_q),
    .din        (bus_wdata),
    .dout       (wdata_fmt)
  );

  // ---- access state ----
  bridge_state_e     state_q, state_d;
  route_t            route_q, route_d;
  logic              we_q, we_d;
  acc_size_e         size_q, size_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              accept;
  logic              load_rd;

  assign rd_src = route_q.hit ? dev_rdata : '1;

  ide_data_fmt #(.DATA_W(DATA_W)) i_rd_fmt (
    .size       (size_q),
    .big_endian (be_q),
    .din        (rd_src),
    .dout       (rdata_fmt)
  );

  assign accept  = (state_q == ST_IDLE) && bus_req;
  assign load_rd = (state_q == ST_ACCESS) && !we_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (bus_req) state_d = ST_ACCESS;
      ST_ACCESS: state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    route_d = route_q;
    we_d    = we_q;
    size_d  = size_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    if (accept) begin
      route_d = req_route;
      we_d    = bus_we;
      size_d  = req_size;
      wdata_d = bus_we ? wdata_fmt : '0;
    end
    if (load_rd) rdata_d = rdata_fmt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      route_q <= '0;
      we_q    <= 1'b0;
      size_q  <= SZ_BYTE;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      route_q <= route_d;
      we_q    <= we_d;
      size_q  <= size_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  // ---- outputs ----
  assign dev_reg   = route_q.sel;
  assign dev_size  = size_q;
  assign dev_wdata = wdata_q;
  assign dev_rd    = (state_q == ST_ACCESS) && route_q.hit && !we_q;
  assign dev_wr    = (state_q == ST_ACCESS) && route_q.hit &&  we_q;
  assign bus_ready = (state_q == ST_DONE);
  assign bus_rdata = rdata_q;

  // ---- assertions ----
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_ready |=> !bus_ready); // R8
  AST_STROBE_TO_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dev_rd || dev_wr) |=> bus_ready); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dev_rd || dev_wr) |=> !(dev_rd || dev_wr)); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({dev_rd, dev_wr}) <= 1); // R9
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_seen_q |=> $stable(be_q)); // R7
  AST_BYTE_NARROW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dev_wr && dev_size == SZ_BYTE) |-> dev_wdata[DATA_W-1:8] == '0); // R2
  AST_WIDE_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((dev_rd || dev_wr) && dev_size != SZ_BYTE) |-> dev_reg == DREG_DATA); // R5

endmodule

// File: tb/test_mmio_ide_bridge.sv
module test_mmio_ide_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'b00;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [3:0]  dev_reg;
  logic [1:0]  dev_size;
  logic [31:0] dev_wdata;
  logic        dev_rd, dev_wr;
  logic [31:0] dev_rdata;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  int rd_strobes = 0;
  logic [31:0] mreg [9];
  logic [31:0] sreg [9];
  logic mode_be = 1'b0;

  always #10 clk = ~clk;

  mmio_ide_bridge i_mmio_ide_bridge (
    .clk, .rst_n, .cfg_big_endian, .bus_req, .bus_we, .bus_size, .bus_addr,
    .bus_wdata, .bus_ready, .bus_rdata, .dev_reg, .dev_size, .dev_wdata,
    .dev_rd, .dev_wr, .dev_rdata
  );

  // drive register stub
  assign dev_rdata = (dev_reg <= 4'd8) ? sreg[dev_reg] : 32'hFFFF_FFFF;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) sreg[i] <= 32'h0;
    end else if (dev_wr && dev_reg <= 4'd8) begin
      sreg[dev_reg] <= dev_wdata;
    end
  end
  always @(negedge clk) begin
    if (dev_rd || dev_wr) strobes <= strobes + 1;
    if (dev_rd) rd_strobes <= rd_strobes + 1;
  end

  function automatic int route(input logic [1:0] sz, input logic [15:0] a);
    logic [7:0] s;
    s = a[11:4];
    if (sz == 2'b00) begin
      if (s >= 8'd1 && s <= 8'd7) return int'(s);
      if (s == 8'd8 || s == 8'd22) return 8;
      return -1;
    end
    return (s == 8'd0) ? 0 : -1;
  endfunction

  function automatic logic [31:0] fmt(input logic [1:0] sz, input logic be, input logic [31:0] v);
    if (sz == 2'b00) return {24'h0, v[7:0]};
    if (sz == 2'b01) return be ? {16'h0, v[7:0], v[15:8]} : {16'h0, v[15:0]};
    return be ? {v[7:0], v[15:8], v[23:16], v[31:24]} : v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [15:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int nstb);
    int s0, r0, cyc;
    @(negedge clk);
    s0 = strobes; r0 = rd_strobes;
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!bus_ready && cyc < 10);
    chk(cyc == 2, "R8 ready latency", 32'(cyc), 32'd2);
    rd = bus_rdata;
    bus_req = 1'b0;
    @(negedge clk);
    chk(!bus_ready, "R8 ready single pulse", {31'h0, bus_ready}, 32'h0);
    nstb = strobes - s0;
    if (!we) chk((rd_strobes - r0) == nstb, "R9 strobe type", 32'(rd_strobes - r0), 32'(nstb));
  endtask

  // full access with model-based checks
  task automatic op(input logic we, input logic [1:0] sz, input logic [15:0] a,
                    input logic [31:0] wd, input string req);
    logic [31:0] rd, exp;
    int n, r;
    r = route(sz, a);
    access(we, sz, a, wd, rd, n);
    chk(n == ((r >= 0) ? 1 : 0), {req, " / R9 strobe count"}, 32'(n), (r >= 0) ? 32'd1 : 32'd0);
    if (we) begin
      if (r >= 0) mreg[r] = fmt(sz, mode_be, wd);
    end else begin
      exp = (r >= 0) ? fmt(sz, mode_be, mreg[r]) : fmt(sz, 1'b0, 32'hFFFF_FFFF);
      chk(rd == exp, {req, " read data"}, rd, exp);
    end
  endtask

  task automatic do_reset(input logic be);
    @(negedge clk);
    rst_n = 1'b0; cfg_big_endian = be;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 9; i++) mreg[i] = 32'h0;
    mode_be = be;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [1:0]  sz;
    void'($urandom(32'd1234));
    do_reset(1'b0);
    // R10 reset state
    chk(!bus_ready && !dev_rd && !dev_wr, "R10 strobes idle", {29'h0, bus_ready, dev_rd, dev_wr}, 32'h0);
    chk(bus_rdata == 32'h0, "R10 rdata", bus_rdata, 32'h0);

    // R2 task-file write/read
    op(1'b1, 2'b00, 16'h0030, 32'hDEAD_BE5A, "R2 tf write");
    op(1'b0, 2'b00, 16'h0030, 32'h0, "R2 tf read");
    op(1'b1, 2'b00, 16'h0070, 32'h0000_0091, "R2 tf7 write");
    op(1'b0, 2'b00, 16'h0070, 32'h0, "R2 tf7 read");
    // R1 ignored high and low offset bits
    op(1'b0, 2'b00, 16'hF03F, 32'h0, "R1 alias high/low");
    op(1'b1, 2'b00, 16'hA03B, 32'h0000_0044, "R1 alias write");
    op(1'b0, 2'b00, 16'h0030, 32'h0, "R1 alias readback");
    // R3 both control slots
    op(1'b1, 2'b00, 16'h0080, 32'h0000_0006, "R3 ctrl slot 8");
    op(1'b0, 2'b00, 16'h0160, 32'h0, "R3 status slot 22");
    op(1'b1, 2'b00, 16'h0165, 32'h0000_0002, "R3 ctrl slot 22");
    op(1'b0, 2'b00, 16'h0080, 32'h0, "R3 status slot 8");
    // R4 unmapped bytes incl. slot 0
    op(1'b0, 2'b00, 16'h0000, 32'h0, "R4 byte slot 0");
    op(1'b1, 2'b00, 16'h0090, 32'h0000_00AA, "R4 byte slot 9 write");
    op(1'b0, 2'b00, 16'h0FF0, 32'h0, "R4 byte slot 255");
    // R5 data port and unmapped wide
    op(1'b1, 2'b10, 16'h0000, 32'h1122_3344, "R5 word write");
    op(1'b0, 2'b10, 16'h0000, 32'h0, "R5 word read");
    op(1'b1, 2'b01, 16'h000C, 32'hFFFF_5566, "R5 half write");
    op(1'b0, 2'b01, 16'h0000, 32'h0, "R5 half read");
    op(1'b1, 2'b01, 16'h0020, 32'h0000_7777, "R5 half slot 2 write");
    op(1'b0, 2'b01, 16'h0020, 32'h0, "R5 half slot 2 read");
    op(1'b0, 2'b10, 16'h0080, 32'h0, "R5 word slot 8 read");
    op(1'b0, 2'b11, 16'h0000, 32'h0, "R5 size 11 read");
    op(1'b0, 2'b01, 16'h0000, 32'h0, "R5 data after ignored write");

    // random, little-endian
    for (int k = 0; k < 300; k++) begin
      sz = 2'($urandom_range(0, 3));
      a  = 16'($urandom);
      if ($urandom_range(0, 1) == 0) a[11:4] = 8'($urandom_range(0, 9));
      if ($urandom_range(0, 7) == 0) a[11:4] = 8'd22;
      op(1'($urandom), sz, a, $urandom, "R1 random");
    end

    // R6/R7 big-endian mode
    do_reset(1'b1);
    op(1'b1, 2'b10, 16'h0000, 32'hA1B2_C3D4, "R6 word swap write");
    chk(sreg[0] == 32'hD4C3_B2A1, "R6 device saw reversed word", sreg[0], 32'hD4C3_B2A1);
    op(1'b0, 2'b10, 16'h0000, 32'h0, "R6 word swap read");
    op(1'b1, 2'b01, 16'h0000, 32'h0000_1234, "R6 half swap write");
    chk(sreg[0] == 32'h0000_3412, "R6 device saw reversed half", sreg[0], 32'h0000_3412);
    op(1'b1, 2'b00, 16'h0020, 32'h0000_00C7, "R6 byte not swapped");
    chk(sreg[2] == 32'h0000_00C7, "R6 byte untouched", sreg[2], 32'h0000_00C7);
    op(1'b0, 2'b00, 16'h0020, 32'h0, "R6 byte read");
    @(negedge clk);
    cfg_big_endian = 1'b0;
    op(1'b1, 2'b10, 16'h0000, 32'h0102_0304, "R7 late cfg change write");
    chk(sreg[0] == 32'h0403_0201, "R7 mode kept", sreg[0], 32'h0403_0201);
    op(1'b0, 2'b01, 16'h0000, 32'h0, "R7 late cfg change read");
    for (int k = 0; k < 150; k++) begin
      sz = 2'($urandom_range(0, 3));
      a  = 16'($urandom);
      if ($urandom_range(0, 1) == 0) a[11:4] = 8'($urandom_range(0, 9));
      op(1'($urandom), sz, a, $urandom, "R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule